// File: doc/BRIEF.md
# Dual-Host Status and Interrupt Register

This block keeps, for each of two hosts sharing one set of peripherals, a 16-bit status word and a small prepare register. It also tracks whether an interrupt is waiting for each host. Each host sees a mirrored view. The bits that describe "the other host" come from that host's flags, and each of those bits is cleared by its own set of events. The command controller, the watchdog and the operator console drive single-cycle event pulses into the block. The block answers with the status word of each host, an interrupt request and its level, and a pending flag. The controller uses the pending flag to produce the busy code.

A status read strobe returns the word one cycle later. The read is refused with a busy pulse when the reading host has an interrupt waiting. An interrupt is held until the host has loaded its prepare register with the enable bit set. Once presented, it stays pending until the host acknowledges it or is reset.

Top module: `host_stat_irq`

## Requirements
- R1: The status word uses big-endian numbering, so word bit n sits at vector index 15-n. Bit 0 is 1 when `owner_i` names this host (0 = side A, 1 = side B). Bit 1 mirrors `manual_i`. Bit 4 mirrors `wd_run_i`. Bit 10 mirrors this host's `ipl_blk_i` strap. Bit 11 is the side (0 for A, 1 for B). All bits not named in R1 to R5 read 0.
- R2: Bit 2 of a host's word is 1 when the other host incurred a watchdog time-out, meaning a `tmo_i` pulse arrived while the other host was owner. The other host's `sys_rst_i` clears it, and so does `console_clr_i`. The other host's `dev_clr_i` (halt or device reset) does not clear it.
- R3: Bit 3 of a host's word is 1 after the other host pulses `reserve_i`. It is cleared by that other host's `sys_rst_i`, `dev_clr_i` or `rnc_i` (reset-and-connect), or by `console_clr_i`.
- R4: While `manual_i` is 1, bits 2 and 3 of both words read 0. The flags behind them are kept and reappear when `manual_i` returns to 0.
- R5: Bit 5 of a host's word is 1 after a `tmo_i` pulse while that host is owner. It is cleared by that host's `sys_rst_i` or by `console_clr_i`.
- R6: A `prep_we_i` pulse loads that host's prepare register from its 16-bit data word. The interrupt enable comes from vector index 0 (operand bit 31). The level comes from indices 4:1 (operand bits 27-30) and appears on `irq_lvl_o`. The host's `sys_rst_i` clears the register.
- R7: A host's pending flag is set by a reserve from the other host, by any `tmo_i` pulse (both hosts), and by `warn_i` for the current owner only.
- R8: `irq_o` is 1 exactly while the host's flag is pending and its enable bit is 1. An interrupt that arrives before the enable is set stays queued and is presented once the enable is loaded.
- R9: `ack_i`, `dev_clr_i` or `sys_rst_i` of a host clears its pending flag. If a set event for that host arrives in the same cycle, the set wins.
- R10: One cycle after `rd_stb_i`, a host whose flag was pending gets `rd_busy_o` and no `rd_vld_o`. Otherwise it gets `rd_vld_o` with `rd_word_o` equal to its status word at the strobe.
- R11: When a flag behind bit 2, 3 or 5 sees a set and a clear in the same cycle, the clear wins.
- R12: After reset, all flags, pending bits, prepare registers and read pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| owner_i | input | 1 | Host connected to the shared bus and watchdog (0 = A) |
| manual_i | input | 1 | Manual control mode |
| wd_run_i | input | 1 | Watchdog running |
| tmo_i | input | 1 | Watchdog time-out pulse |
| warn_i | input | 1 | Watchdog warning pulse |
| console_clr_i | input | 1 | Console clear pulse |
| ipl_blk_i | input | 2 | Per-host IPL-blocked strap |
| sys_rst_i | input | 2 | Per-host system reset pulse |
| dev_clr_i | input | 2 | Per-host halt or device reset pulse |
| rnc_i | input | 2 | Per-host reset-and-connect executed |
| reserve_i | input | 2 | Per-host reserve executed |
| prep_we_i | input | 2 | Per-host prepare write |
| prep_data_i | input | 2x16 | Per-host prepare data word |
| ack_i | input | 2 | Per-host interrupt acknowledge |
| rd_stb_i | input | 2 | Per-host status read strobe |
| status_o | output | 2x16 | Per-host status word |
| irq_o | output | 2 | Per-host interrupt request |
| irq_lvl_o | output | 2x4 | Per-host interrupt level |
| pend_o | output | 2 | Per-host interrupt pending |
| rd_vld_o | output | 2 | Read accepted pulse |
| rd_busy_o | output | 2 | Read refused pulse |
| rd_word_o | output | 2x16 | Word returned by an accepted read |

## Verification
The bench builds the block with the default widths: a 16-bit status word, a 16-bit prepare data word and a 4-bit level. With these widths the field positions stated in R1 and R6 are exercised exactly as numbered. A table of event steps with cumulative state drives both mirrored views through reserve, time-out, manual masking and each clear path, including a same-cycle set and clear. Directed tests then cover queued interrupts, acknowledge races and busy-refused reads.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  localparam int unsigned HOSTS = 2;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  // big-endian status numbering -> vector index
  function automatic int unsigned sidx(input int unsigned n, input int unsigned w);
    return w - 1 - n;
  endfunction
endpackage

// File: rtl/hsi_sticky.sv
module hsi_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;  // clear wins
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/hsi_word.sv
module hsi_word
  import hsi_pkg::*;
#(
  parameter int unsigned SW   = 16,
  parameter bit          SIDE = 1'b0
) (
  input  logic          conn_i,
  input  logic          manual_i,
  input  logic          oth_tmo_i,
  input  logic          oth_rsv_i,
  input  logic          wd_run_i,
  input  logic          own_tmo_i,
  input  logic          ipl_blk_i,
  output logic [SW-1:0] word_o
);
  localparam int unsigned I_CONN = sidx(0, SW);
  localparam int unsigned I_MAN  = sidx(1, SW);
  localparam int unsigned I_OTMO = sidx(2, SW);
  localparam int unsigned I_ORSV = sidx(3, SW);
  localparam int unsigned I_RUN  = sidx(4, SW);
  localparam int unsigned I_TMO  = sidx(5, SW);
  localparam int unsigned I_IPL  = sidx(10, SW);
  localparam int unsigned I_SIDE = sidx(11, SW);

  always_comb begin
    word_o         = '0;
    word_o[I_CONN] = conn_i;
    word_o[I_MAN]  = manual_i;
    word_o[I_OTMO] = oth_tmo_i & ~manual_i;
    word_o[I_ORSV] = oth_rsv_i & ~manual_i;
    word_o[I_RUN]  = wd_run_i;
    word_o[I_TMO]  = own_tmo_i;
    word_o[I_IPL]  = ipl_blk_i;
    word_o[I_SIDE] = SIDE;
  end
endmodule

// File: rtl/hsi_irq.sv
module hsi_irq #(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 4,
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prep_we_i,
  input  logic [DW-1:0] prep_data_i,
  input  logic          prep_clr_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic          rd_stb_i,
  input  logic [SW-1:0] word_i,
  output logic          irq_o,
  output logic [LW-1:0] lvl_o,
  output logic          pend_o,
  output logic          rd_vld_o,
  output logic          rd_busy_o,
  output logic [SW-1:0] rd_word_o
);
  localparam int unsigned EN_POS  = 0;
  localparam int unsigned LVL_LSB = EN_POS + 1;

  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      lvl_o <= '0;
    end else if (prep_clr_i) begin
      en_q  <= 1'b0;
      lvl_o <= '0;
    end else if (prep_we_i) begin
      en_q  <= prep_data_i[EN_POS];
      lvl_o <= prep_data_i[LVL_LSB +: LW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;  // set wins
    else if (clr_i) pend_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_busy_o <= 1'b0;
      rd_word_o <= '0;
    end else begin
      rd_vld_o  <= rd_stb_i & ~pend_o;
      rd_busy_o <= rd_stb_i & pend_o;
      if (rd_stb_i && !pend_o) rd_word_o <= word_i;
    end
  end

  assign irq_o = pend_o & en_q;
endmodule

// File: rtl/host_stat_irq.sv
module host_stat_irq
  import hsi_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 16,
  parameter int unsigned LW = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     owner_i,
  input  logic                     manual_i,
  input  logic                     wd_run_i,
  input  logic                     tmo_i,
  input  logic                     warn_i,
  input  logic                     console_clr_i,
  input  logic [HOSTS-1:0]         ipl_blk_i,
  input  logic [HOSTS-1:0]         sys_rst_i,
  input  logic [HOSTS-1:0]         dev_clr_i,
  input  logic [HOSTS-1:0]         rnc_i,
  input  logic [HOSTS-1:0]         reserve_i,
  input  logic [HOSTS-1:0]         prep_we_i,
  input  logic [HOSTS-1:0][DW-1:0] prep_data_i,
  input  logic [HOSTS-1:0]         ack_i,
  input  logic [HOSTS-1:0]         rd_stb_i,
  output logic [HOSTS-1:0][SW-1:0] status_o,
  output logic [HOSTS-1:0]         irq_o,
  output logic [HOSTS-1:0][LW-1:0] irq_lvl_o,
  output logic [HOSTS-1:0]         pend_o,
  output logic [HOSTS-1:0]         rd_vld_o,
  output logic [HOSTS-1:0]         rd_busy_o,
  output logic [HOSTS-1:0][SW-1:0] rd_word_o
);
  logic [HOSTS-1:0] rsv_q, tmo_q;

  for (genvar h = 0; h < HOSTS; h++) begin : g_host
    localparam int unsigned O = HOSTS - 1 - h;
    logic is_owner;
    assign is_owner = (owner_i == 1'(h));

    hsi_sticky u_rsv (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (reserve_i[h]),
      .clr_i (sys_rst_i[h] | dev_clr_i[h] | rnc_i[h] | console_clr_i),
      .q_o   (rsv_q[h])
    );

    hsi_sticky u_tmo (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (tmo_i & is_owner),
      .clr_i (sys_rst_i[h] | console_clr_i),
      .q_o   (tmo_q[h])
    );

    hsi_word #(.SW(SW), .SIDE(1'(h))) u_word (
      .conn_i   (is_owner),
      .manual_i (manual_i),
      .oth_tmo_i(tmo_q[O]),
      .oth_rsv_i(rsv_q[O]),
      .wd_run_i (wd_run_i),
      .own_tmo_i(tmo_q[h]),
      .ipl_blk_i(ipl_blk_i[h]),
      .word_o   (status_o[h])
    );

    hsi_irq #(.DW(DW), .LW(LW), .SW(SW)) u_irq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .prep_we_i  (prep_we_i[h]),
      .prep_data_i(prep_data_i[h]),
      .prep_clr_i (sys_rst_i[h]),
      .set_i      (reserve_i[O] | tmo_i | (warn_i & is_owner)),
      .clr_i      (ack_i[h] | dev_clr_i[h] | sys_rst_i[h]),
      .rd_stb_i   (rd_stb_i[h]),
      .word_i     (status_o[h]),
      .irq_o      (irq_o[h]),
      .lvl_o      (irq_lvl_o[h]),
      .pend_o     (pend_o[h]),
      .rd_vld_o   (rd_vld_o[h]),
      .rd_busy_o  (rd_busy_o[h]),
      .rd_word_o  (rd_word_o[h])
    );
  end
endmodule

// File: rtl/hsi_chk.sv
module hsi_chk
  import hsi_pkg::*;
#(
  parameter int unsigned SW = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     owner_i,
  input logic                     manual_i,
  input logic                     tmo_i,
  input logic                     warn_i,
  input logic [HOSTS-1:0]         sys_rst_i,
  input logic [HOSTS-1:0]         dev_clr_i,
  input logic [HOSTS-1:0]         reserve_i,
  input logic [HOSTS-1:0]         ack_i,
  input logic [HOSTS-1:0]         rd_stb_i,
  input logic [HOSTS-1:0][SW-1:0] status_o,
  input logic [HOSTS-1:0]         irq_o,
  input logic [HOSTS-1:0]         pend_o,
  input logic [HOSTS-1:0]         rd_vld_o,
  input logic [HOSTS-1:0]         rd_busy_o
);
  localparam int unsigned I_OTMO = sidx(2, SW);
  localparam int unsigned I_ORSV = sidx(3, SW);
  localparam int unsigned I_TMO  = sidx(5, SW);

  for (genvar h = 0; h < HOSTS; h++) begin : g_chk
    localparam int unsigned O = HOSTS - 1 - h;

    // R8
    irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[h] |-> pend_o[h]);

    // R4
    manual_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      manual_i |-> (!status_o[h][I_OTMO] && !status_o[h][I_ORSV]));

    // R5
    own_tmo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_rst_i[h] |=> !status_o[h][I_TMO]);

    // R3
    oth_rsv_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dev_clr_i[O] |=> !status_o[h][I_ORSV]);

    // R10
    busy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_stb_i[h] && pend_o[h]) |=> (rd_busy_o[h] && !rd_vld_o[h]));

    // R9
    ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[h] && !reserve_i[O] && !tmo_i && !(warn_i && owner_i == 1'(h)))
        |=> !pend_o[h]);
  end
endmodule

bind host_stat_irq hsi_chk #(.SW(SW)) u_hsi_chk (.*);

// File: tb/tb_host_stat_irq.sv
module tb_host_stat_irq;
  localparam int unsigned DW = 16;
  localparam int unsigned SW = 16;
  localparam int unsigned LW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic owner_i = 1'b0, manual_i = 1'b0, wd_run_i = 1'b0;
  logic tmo_i = 1'b0, warn_i = 1'b0, console_clr_i = 1'b0;
  logic [1:0] ipl_blk_i = 2'b10;
  logic [1:0] sys_rst_i = '0, dev_clr_i = '0, rnc_i = '0, reserve_i = '0;
  logic [1:0] prep_we_i = '0, ack_i = '0, rd_stb_i = '0;
  logic [1:0][DW-1:0] prep_data_i = '0;
  logic [1:0][SW-1:0] status_o, rd_word_o;
  logic [1:0] irq_o, pend_o, rd_vld_o, rd_busy_o;
  logic [1:0][LW-1:0] irq_lvl_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  host_stat_irq #(.DW(DW), .SW(SW), .LW(LW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr_pulses();
    tmo_i = 0; warn_i = 0; console_clr_i = 0;
    sys_rst_i = '0; dev_clr_i = '0; rnc_i = '0; reserve_i = '0;
    prep_we_i = '0; ack_i = '0; rd_stb_i = '0;
  endtask

  typedef struct packed {
    logic [1:0] rsv, srst, dclr, rnc;
    logic       cclr, tmo, owner, manual;
    logic [2:0] ea, eb;   // {bit2, bit3, bit5}
    logic [1:0] ep;       // {pend B, pend A}
  } step_t;

  localparam step_t TBL [12] = '{
    '{2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b010, 2'b10},
    '{2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 3'b001, 3'b110, 2'b11},
    '{2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 3'b000, 2'b11},
    '{2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 3'b100, 2'b10},
    '{2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b011, 3'b100, 2'b11},
    '{2'b00, 2'b00, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 3'b100, 2'b11},
    '{2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 2'b10},
    '{2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 3'b100, 3'b001, 2'b11},
    '{2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b110, 3'b011, 2'b11},
    '{2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 2'b11},
    '{2'b00, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 2'b00},
    '{2'b01, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 2'b10}
  };

  initial begin
    #80000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 / R1 reset view
    chk("R12 status A", status_o[0], 32'h8000);
    chk("R12 status B", status_o[1], 32'h0030);
    chk("R12 pend", pend_o, 0);
    chk("R12 irq", irq_o, 0);
    chk("R12 rd pulses", {rd_vld_o, rd_busy_o}, 0);
    // R1 level bits
    manual_i = 1; wd_run_i = 1;
    @(negedge clk_i);
    chk("R1 manual+run A", status_o[0], 32'hC800);
    chk("R1 manual+run B", status_o[1], 32'h4830);
    manual_i = 0; wd_run_i = 0;

    // R2 R3 R4 R5 R7 R9 R11 table walk
    foreach (TBL[i]) begin
      @(negedge clk_i);
      reserve_i = TBL[i].rsv; sys_rst_i = TBL[i].srst; dev_clr_i = TBL[i].dclr;
      rnc_i = TBL[i].rnc; console_clr_i = TBL[i].cclr; tmo_i = TBL[i].tmo;
      owner_i = TBL[i].owner; manual_i = TBL[i].manual;
      @(negedge clk_i);
      clr_pulses();
      chk($sformatf("R2/R3/R4/R5/R11 step %0d A", i),
          {status_o[0][13], status_o[0][12], status_o[0][10]}, TBL[i].ea);
      chk($sformatf("R2/R3/R4/R5/R11 step %0d B", i),
          {status_o[1][13], status_o[1][12], status_o[1][10]}, TBL[i].eb);
      chk($sformatf("R7/R9 step %0d pend", i), pend_o, TBL[i].ep);
    end
    // owner B now, pend B=1, A=0

    // R9 ack clears
    ack_i = 2'b10;
    @(negedge clk_i); clr_pulses();
    chk("R9 ack B", pend_o, 2'b00);

    // R6 prepare A: level 5, enable
    prep_we_i = 2'b01; prep_data_i[0] = 16'h000B;
    @(negedge clk_i); clr_pulses();
    chk("R6 level A", irq_lvl_o[0], 5);
    chk("R8 no pend no irq", irq_o, 0);

    // R7 warning goes to owner only
    warn_i = 1;
    @(negedge clk_i); clr_pulses();
    chk("R7 warn owner only", pend_o, 2'b10);

    // R8 reserve by B presents on A
    reserve_i = 2'b10;
    @(negedge clk_i); clr_pulses();
    chk("R8 irq A", irq_o, 2'b01);

    // R10 read while pending refused
    rd_stb_i = 2'b01;
    @(negedge clk_i); clr_pulses();
    chk("R10 busy A", {rd_vld_o[0], rd_busy_o[0]}, 2'b01);

    ack_i = 2'b01;
    @(negedge clk_i); clr_pulses();
    chk("R9 ack A irq", irq_o[0], 0);

    // R10 accepted read returns word
    rd_stb_i = 2'b01;
    @(negedge clk_i); clr_pulses();
    chk("R10 vld A", {rd_vld_o[0], rd_busy_o[0]}, 2'b10);
    chk("R10 word A", rd_word_o[0], 32'h1000);

    // R8 queued until enabled
    prep_we_i = 2'b10; prep_data_i[1] = 16'h0004;
    @(negedge clk_i); clr_pulses();
    chk("R8 queued B", {irq_o[1], pend_o[1]}, 2'b01);
    chk("R6 level B", irq_lvl_o[1], 2);
    prep_we_i = 2'b10; prep_data_i[1] = 16'h0005;
    @(negedge clk_i); clr_pulses();
    chk("R8 presented B", irq_o[1], 1);

    // R9 set wins over ack same cycle
    ack_i = 2'b10; reserve_i = 2'b01;
    @(negedge clk_i); clr_pulses();
    chk("R9 set wins B", pend_o[1], 1);

    // R6 system reset clears prepare
    sys_rst_i = 2'b10;
    @(negedge clk_i); clr_pulses();
    chk("R6 prep cleared B", {irq_o[1], irq_lvl_o[1]}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule